// File: doc/BRIEF.md
# Optimal-Filter Pulse Amplitude and Time Estimator

This block sits behind a calorimeter digitizer. Pulse samples arrive as a stream. A trigger marks the event of interest. The block then takes the next five accepted samples and subtracts a programmable baseline from each one. It forms two weighted sums over the window. The first sum estimates the pulse amplitude. The second estimates the amplitude multiplied by the time offset of the pulse. A later stage divides the second result by the first to obtain the time.

The weights are stored as signed Q2.14 values. They come out of reset holding the values tuned for the nominal pulse shape, with the peak on the third sample. They can be replaced through a small register write port. Each pair of results leaves the block through a valid/ready output.

Back-pressure works as follows:
- The sample input uses `s_valid`/`s_ready`. A sample is taken only in a cycle where both are high.
- `s_ready` drops in the cycle after the fifth sample of a window is taken. It stays low until that window has moved into the multiply stage.
- The multiply stage can only move forward when the output register is free, or is being emptied in the same cycle. A stalled output therefore holds `s_ready` low.

Top module: `ofe_estimator`

## Requirements
- R1: A sample is accepted when `s_valid` and `s_ready` are both high. After the fifth sample of a window is accepted, `s_ready` is low for at least the next cycle. It stays low until the finished window moves into the multiply stage.
- R2: A window starts with the first sample accepted in a cycle strictly later than the cycle in which a trigger was seen. Samples accepted while no trigger is pending and no window is open are discarded and produce no result.
- R3: A trigger is ignored while a window holds one to four samples, and in the cycle a window starts. A trigger repeated while one is already pending has no further effect.
- R4: Each accepted sample (12-bit unsigned) has the current baseline subtracted from it. The difference is kept as a 13-bit signed value, tagged with its position 0..4 in the window.
- R5: `o_amp` equals round(Σ d_i·A_i / 2^14), where d_i is the baseline-corrected sample at position i and A_i is the amplitude weight for that position.
- R6: `o_atm` equals round(Σ d_i·T_i / 2^14), using the timing weights T_i. It is delivered in the same cycle as `o_amp`.
- R7: Rounding adds 2^13 and then shifts right arithmetically by 14, so ties round upward. The result is then clipped to the signed range of `OUT_W` bits.
- R8: A write with `cfg_we` high updates one register at the clock edge. Address 0..4 selects amplitude weight i. Address 8..12 selects timing weight i−8. Address 15 loads the baseline from `cfg_wdata[11:0]`. Writes to any other address change nothing. A window picks up the weights that are in place when it enters the multiply stage. A sample picks up the baseline that is in place when it is accepted.
- R9: With no back-pressure, `o_valid` rises two clock edges after the edge that accepts the fifth sample. `o_valid` is then high for exactly one cycle per window.
- R10: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_amp` and `o_atm` hold their values.
- R11: Synchronous reset sets the following state:
  - the sample count and the pending trigger are cleared;
  - the pipeline is emptied, so `o_valid` is low and `s_ready` is high;
  - both outputs are zero;
  - the baseline is zero;
  - the weights return to their defaults. Amplitude weights are 2785, 5571, 6554, 5079, 4588 and timing weights are −12288, 7700, 12288, 1147, −3113, each listed for positions 0..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger pulse that arms the next window |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | SMP_W | Unsigned ADC sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | COEF_W | Write data: a weight, or the baseline in the low bits |
| o_valid | output | 1 | Result pair present |
| o_ready | input | 1 | Consumer takes the result pair |
| o_amp | output | OUT_W | Signed amplitude estimate |
| o_atm | output | OUT_W | Signed amplitude × time estimate |

## Verification
The hardest case to reach is a finished window stalled behind a result that the consumer has not yet taken. To get there, a trigger, gaps in `s_valid` and a low `o_ready` must line up so that the multiply stage and the output register are both full while `s_ready` is low. The stimulus reaches this state by running long stretches in which trigger, sample gaps and output stalls are all randomized together. A behavioural model runs alongside and predicts `s_ready` and the outputs on every clock. Clipping cannot occur with 18-bit outputs, so a second instance with 14-bit outputs is fed windows of full-scale samples at extreme baselines.

// File: rtl/ofe_pkg.sv
package ofe_pkg;
  localparam int NTAP   = 5;
  localparam int CNT_W  = 3;
  localparam int CFG_AW = 4;

  function automatic int amp_default(int idx);
    case (idx)
      0: return 2785;
      1: return 5571;
      2: return 6554;
      3: return 5079;
      default: return 4588;
    endcase
  endfunction

  function automatic int tim_default(int idx);
    case (idx)
      0: return -12288;
      1: return 7700;
      2: return 12288;
      3: return 1147;
      default: return -3113;
    endcase
  endfunction
endpackage

// File: rtl/ofe_coef_bank.sv
module ofe_coef_bank
  import ofe_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int COEF_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [COEF_W-1:0]               cfg_wdata,
  output logic [NTAP-1:0][COEF_W-1:0]     amp_w,
  output logic [NTAP-1:0][COEF_W-1:0]     tim_w,
  output logic [SMP_W-1:0]                ped
);
  localparam int TIM_BASE = 1 << (CFG_AW - 1);
  localparam logic [CFG_AW-1:0] PED_ADDR = '1;

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) begin
        amp_w[t] <= COEF_W'(amp_default(t));
        tim_w[t] <= COEF_W'(tim_default(t));
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(t))            amp_w[t] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(TIM_BASE + t)) tim_w[t] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                ped <= '0;
    else if (cfg_we && cfg_addr == PED_ADDR) ped <= cfg_wdata[SMP_W-1:0];
  end
endmodule

// File: rtl/ofe_window.sv
module ofe_window
  import ofe_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int DIFF_W = SMP_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          trig,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [SMP_W-1:0]              s_data,
  input  logic [SMP_W-1:0]              ped,
  input  logic                          hand_off,
  output logic [NTAP-1:0][DIFF_W-1:0]   win,
  output logic                          win_full,
  output logic [CNT_W-1:0]              cnt,
  output logic                          armed
);
  logic [CNT_W-1:0]        cnt_q;
  logic                    armed_q, full_q;
  logic                    acc, collecting, start, take, last;
  logic signed [DIFF_W-1:0] diff;

  assign s_ready    = !full_q;
  assign acc        = s_valid && !full_q;
  assign collecting = (cnt_q != '0);
  assign start      = acc && armed_q && !collecting;
  assign take       = start || (acc && collecting);
  assign last       = acc && collecting && (cnt_q == CNT_W'(NTAP - 1));
  assign diff       = $signed({1'b0, s_data}) - $signed({1'b0, ped});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (start)                                   armed_q <= 1'b0;
      else if (trig && !collecting && !armed_q)    armed_q <= 1'b1;
      if (take) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (last)          full_q <= 1'b1;
      else if (hand_off) full_q <= 1'b0;
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                 win[t] <= '0;
      else if (take && cnt_q == CNT_W'(t))     win[t] <= diff;
    end
  end

  assign win_full = full_q;
  assign cnt      = cnt_q;
  assign armed    = armed_q;
endmodule

// File: rtl/ofe_mac.sv
module ofe_mac
  import ofe_pkg::*;
#(
  parameter int DIFF_W = 13,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 18
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NTAP-1:0][DIFF_W-1:0]   win,
  input  logic [NTAP-1:0][COEF_W-1:0]   wts,
  input  logic                          load_prod,
  input  logic                          load_out,
  output logic [OUT_W-1:0]              result
);
  localparam int PROD_W = DIFF_W + COEF_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OMIN = ACC_W'(-(64'sd1 <<< (OUT_W - 1)));

  logic signed [PROD_W-1:0] prod_q [NTAP];
  logic signed [ACC_W-1:0]  sum, rnd;

  for (genvar t = 0; t < NTAP; t++) begin : g_mul
    logic signed [PROD_W-1:0] d_ext, w_ext;
    assign d_ext = PROD_W'($signed(win[t]));
    assign w_ext = PROD_W'($signed(wts[t]));
    always_ff @(posedge clk) begin
      if (rst)            prod_q[t] <= '0;
      else if (load_prod) prod_q[t] <= d_ext * w_ext;
    end
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < NTAP; t++) sum = sum + ACC_W'(prod_q[t]);
    rnd = (sum + HALF) >>> FRAC_W;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (load_out) begin
      if (rnd > OMAX)      result <= OMAX[OUT_W-1:0];
      else if (rnd < OMIN) result <= OMIN[OUT_W-1:0];
      else                 result <= rnd[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/ofe_estimator.sv
module ofe_estimator
  import ofe_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [SMP_W-1:0]   s_data,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [COEF_W-1:0]  cfg_wdata,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [OUT_W-1:0]   o_amp,
  output logic [OUT_W-1:0]   o_atm
);
  localparam int DIFF_W = SMP_W + 1;
  localparam int NCH    = 2;

  logic [NTAP-1:0][COEF_W-1:0] amp_w, tim_w;
  logic [SMP_W-1:0]            ped;
  logic [NTAP-1:0][DIFF_W-1:0] win;
  logic                        win_full, win_armed;
  logic [CNT_W-1:0]            win_cnt;
  logic                        prod_v_q, out_v_q, prod_take, out_take;
  logic [OUT_W-1:0]            res [NCH];

  assign out_take  = prod_v_q && (!out_v_q || o_ready);
  assign prod_take = win_full && (!prod_v_q || out_take);

  ofe_coef_bank #(.SMP_W(SMP_W), .COEF_W(COEF_W)) u_coef (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata,
    .amp_w, .tim_w, .ped
  );

  ofe_window #(.SMP_W(SMP_W), .DIFF_W(DIFF_W)) u_win (
    .clk, .rst, .trig, .s_valid, .s_ready, .s_data, .ped,
    .hand_off(prod_take), .win, .win_full, .cnt(win_cnt), .armed(win_armed)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ofe_mac #(.DIFF_W(DIFF_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
              .ACC_W(ACC_W), .OUT_W(OUT_W)) u_mac (
      .clk, .rst, .win,
      .wts(c == 0 ? amp_w : tim_w),
      .load_prod(prod_take), .load_out(out_take),
      .result(res[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_v_q <= 1'b0;
      out_v_q  <= 1'b0;
    end else begin
      if (prod_take)     prod_v_q <= 1'b1;
      else if (out_take) prod_v_q <= 1'b0;
      if (out_take)      out_v_q  <= 1'b1;
      else if (o_ready)  out_v_q  <= 1'b0;
    end
  end

  assign o_valid = out_v_q;
  assign o_amp   = res[0];
  assign o_atm   = res[1];
endmodule

// File: rtl/ofe_estimator_chk.sv
module ofe_estimator_chk
  import ofe_pkg::*;
#(
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             o_valid,
  input logic             o_ready,
  input logic [OUT_W-1:0] o_amp,
  input logic [OUT_W-1:0] o_atm,
  input logic             out_take,
  input logic [CNT_W-1:0] win_cnt,
  input logic             win_armed
);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_amp) && $stable(o_atm)));

  // R9
  lat_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_take |=> o_valid);

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (win_cnt == CNT_W'(NTAP - 1) && s_valid && s_ready) |=> !s_ready);

  // R3
  trig_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (win_cnt != '0) |=> !$rose(win_armed));

  // R2
  no_arm_start_chk: assert property (@(posedge clk) disable iff (rst)
    (win_cnt == '0 && !win_armed && s_valid && s_ready) |=> (win_cnt == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    win_cnt <= CNT_W'(NTAP - 1));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!o_valid && s_ready && win_cnt == '0 && !win_armed));
endmodule

bind ofe_estimator ofe_estimator_chk #(.OUT_W(OUT_W)) u_chk (
  .clk, .rst, .s_valid, .s_ready, .o_valid, .o_ready, .o_amp, .o_atm,
  .out_take, .win_cnt, .win_armed
);

// File: tb/ofe_estimator_tb_top.sv
module ofe_estimator_tb_top;
  localparam int NW = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0, s_valid = 1'b0, cfg_we = 1'b0, o_ready = 1'b1;
  logic [11:0] s_data = '0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        s_ready, o_valid, s_ready_n, o_valid_n;
  logic [17:0] o_amp, o_atm;
  logic [NW-1:0] o_amp_n, o_atm_n;

  int checks = 0, errors = 0, pulses = 0;
  string tag = "R11";

  always #10 clk = ~clk;

  ofe_estimator dut_i (
    .clk, .rst, .trig, .s_valid, .s_ready, .s_data, .cfg_we, .cfg_addr,
    .cfg_wdata, .o_valid, .o_ready, .o_amp, .o_atm
  );

  ofe_estimator #(.OUT_W(NW)) dut_n (
    .clk, .rst, .trig, .s_valid, .s_ready(s_ready_n), .s_data, .cfg_we,
    .cfg_addr, .cfg_wdata, .o_valid(o_valid_n), .o_ready,
    .o_amp(o_amp_n), .o_atm(o_atm_n)
  );

  // behavioural reference state
  int     m_wa[5], m_wt[5], m_win[5];
  int     m_ped, m_cnt;
  bit     m_armed, m_full, m_pv, m_ov;
  longint m_pa, m_pt;
  longint m_oa, m_ot;

  function automatic longint rnd(longint x);
    return (x + 8192) >>> 14;
  endfunction

  function automatic longint clip(longint x, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    return x > hi ? hi : (x < lo ? lo : x);
  endfunction

  task automatic model_reset();
    m_wa = '{2785, 5571, 6554, 5079, 4588};
    m_wt = '{-12288, 7700, 12288, 1147, -3113};
    m_win = '{0, 0, 0, 0, 0};
    m_ped = 0; m_cnt = 0; m_armed = 0; m_full = 0; m_pv = 0; m_ov = 0;
    m_pa = 0; m_pt = 0; m_oa = 0; m_ot = 0;
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0d exp=%0d", req, tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit acc, ot, pt, coll, last, start;
    int d;
    acc   = s_valid && !m_full;
    ot    = m_pv && (!m_ov || o_ready);
    pt    = m_full && (!m_pv || ot);
    coll  = (m_cnt != 0);
    start = acc && m_armed && !coll;
    last  = acc && coll && (m_cnt == 4);
    if (ot) begin m_oa = rnd(m_pa); m_ot = rnd(m_pt); m_ov = 1; end
    else if (o_ready) m_ov = 0;
    if (pt) begin
      m_pa = 0; m_pt = 0;
      for (int t = 0; t < 5; t++) begin
        m_pa += longint'(m_win[t]) * m_wa[t];
        m_pt += longint'(m_win[t]) * m_wt[t];
      end
      m_pv = 1;
    end else if (ot) m_pv = 0;
    d = int'(s_data) - m_ped;
    if (start) begin m_win[0] = d; m_cnt = 1; m_armed = 0; end
    else if (acc && coll) begin m_win[m_cnt] = d; m_cnt = last ? 0 : m_cnt + 1; end
    else if (trig && !coll && !m_armed) m_armed = 1;
    if (pt) m_full = 0;
    if (last) m_full = 1;
    if (cfg_we) begin
      if (cfg_addr <= 4) m_wa[cfg_addr] = int'($signed(cfg_wdata));
      else if (cfg_addr >= 8 && cfg_addr <= 12) m_wt[cfg_addr - 8] = int'($signed(cfg_wdata));
      else if (cfg_addr == 15) m_ped = int'(cfg_wdata[11:0]);
    end
  endtask

  // inputs are already driven for this cycle; compare, advance model, move to next low phase
  task automatic tick();
    #1;
    check(s_ready == !m_full, "R1", "s_ready", s_ready, !m_full);
    check(s_ready_n == !m_full, "R1", "s_ready narrow", s_ready_n, !m_full);
    check(o_valid == m_ov, "R9", "o_valid", o_valid, m_ov);
    check(o_valid_n == m_ov, "R9", "o_valid narrow", o_valid_n, m_ov);
    if (m_ov) begin
      check($signed(o_amp) == clip(m_oa, 18), "R5", "o_amp", $signed(o_amp), clip(m_oa, 18));
      check($signed(o_atm) == clip(m_ot, 18), "R6", "o_atm", $signed(o_atm), clip(m_ot, 18));
      check($signed(o_amp_n) == clip(m_oa, NW), "R7", "o_amp narrow", $signed(o_amp_n), clip(m_oa, NW));
      check($signed(o_atm_n) == clip(m_ot, NW), "R7", "o_atm narrow", $signed(o_atm_n), clip(m_ot, NW));
      if (o_ready) pulses++;
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
    trig = 0; cfg_we = 0;
  endtask

  task automatic send(int v);
    s_valid = 1; s_data = 12'(v);
    tick();
    while (!m_full && 0) tick();
  endtask

  task automatic idle(int n);
    s_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic shaped_window(int ped, int amp, bit trig_all);
    int shp[5] = '{0, 630, 1000, 800, 470};
    trig = 1; s_valid = 1; s_data = 12'(ped); tick();
    for (int i = 0; i < 5; i++) begin
      trig = trig_all;
      s_valid = 1; s_data = 12'(ped + (amp * shp[i]) / 1000);
      tick();
    end
    idle(4);
  endtask

  task automatic cfg(int a, int v);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 16'(v); s_valid = 0;
    tick();
  endtask

  task automatic random_run(int n, bit with_cfg);
    for (int i = 0; i < n; i++) begin
      trig    = ($urandom_range(0, 7) == 0);
      s_valid = ($urandom_range(0, 3) != 0);
      s_data  = 12'($urandom_range(0, 4095));
      o_ready = ($urandom_range(0, 2) != 0);
      if (with_cfg && $urandom_range(0, 40) == 0) begin
        cfg_we = 1; cfg_addr = 4'($urandom_range(0, 15));
        cfg_wdata = 16'($urandom_range(0, 65535));
        if (cfg_addr == 15) cfg_wdata = 16'($urandom_range(0, 600));
      end
      tick();
    end
    o_ready = 1;
    idle(10);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: state right after reset
    check(o_valid == 0, "R11", "o_valid after reset", o_valid, 0);
    check(s_ready == 1, "R11", "s_ready after reset", s_ready, 1);
    check(o_amp == 0 && o_atm == 0, "R11", "outputs zero", o_amp, 0);
    rst = 0;
    #1;

    tag = "R11 default weights";
    shaped_window(0, 2000, 0);
    tag = "R4 baseline";
    cfg(15, 200);
    shaped_window(200, 3000, 0);
    tag = "R2 no trigger";
    s_valid = 1;
    for (int i = 0; i < 12; i++) begin s_data = 12'(i * 100); tick(); end
    idle(3);
    tag = "R3 repeated trigger";
    shaped_window(200, 1500, 1);
    trig = 1; tick(); trig = 1; tick();
    shaped_window(200, 900, 0);
    tag = "R8 writes";
    cfg(2, -5000);
    cfg(12, 9000);
    for (int a = 5; a < 8; a++) cfg(a, 16'h7fff);
    cfg(13, 16'h7fff); cfg(14, 16'h7fff);
    shaped_window(200, 2500, 0);
    tag = "R7 clipping";
    cfg(15, 0);
    cfg(2, 30000); cfg(1, 30000);
    shaped_window(0, 4095, 0);
    trig = 1; tick();
    for (int i = 0; i < 5; i++) begin s_valid = 1; s_data = 12'd4095; tick(); end
    idle(4);
    cfg(15, 4095);
    trig = 1; tick();
    for (int i = 0; i < 5; i++) begin s_valid = 1; s_data = 12'd0; tick(); end
    idle(4);
    tag = "R9 R10 back-pressure";
    cfg(15, 100);
    random_run(3000, 0);
    tag = "R8 random config";
    random_run(3000, 1);

    check(pulses > 20, "R9", "result pulses seen", pulses, 21);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule